// File: doc/BRIEF.md
# DAC Setpoint Source Selector with Interpolating Ramp

This block produces the parallel code for a current-setting DAC. The target code comes from one of two places. One is a setpoint register written by the local processor. The other is an external parallel bus. The parallel bus is used only when an add-on board reports its presence on an active-low detect input and the unit is in remote mode. In every other combination the processor register is used.

When ramping is off, the output jumps to a new target in one step. When ramping is on, an interpolating counter walks the output toward the target. It moves by a programmable step once per programmable tick interval and lands exactly on the target. A target that changes during a ramp starts a new ramp from the value the output holds at that moment.

There is also a monitor-only mode, used when an external controller drives the DAC. In this mode the block releases its output enable and copies the sensed DAC bits into its code register for display.

Top module: `dac_setpoint_ramp`

## Requirements
- R1: Only the low ACT_W bits of any source reach `dac_code`. Bits ACT_W and above always read zero.
- R2: A `cpu_wr` pulse captures `cpu_setpoint` at a rising edge. In direct mode the captured value appears on `dac_code` at the following rising edge.
- R3: With `board_det_n` low and `remote_mode` high, the target is `par_bus`. In direct mode `dac_code` equals the masked bus one rising edge after the bus is applied.
- R4: If `board_det_n` is high or `remote_mode` is low, the target is the processor register and `par_bus` has no effect on `dac_code`.
- R5: While `mon_only` is high, `dac_oe` is low one edge later and `dac_code` shows the masked `dac_sense` one edge later. Processor writes, the parallel bus and the ramp controls do not alter `dac_code` in this mode.
- R6: With `ramp_en` low, `dac_code` takes the target in a single step one edge later. This also applies when a ramp is in progress at the moment `ramp_en` drops.
- R7: With `ramp_en` high, the output moves by `step_size` once every `tick_div`+1 clocks. A `step_size` of 0 moves it by 1. After a target change is registered (edge e1), the k-th step lands at edge e1 + k·(`tick_div`+1).
- R8: A ramp stops exactly on the target with no overshoot, both upward and downward. The output then holds.
- R9: A target change during a ramp restarts the tick interval. The new ramp continues from the output value at that moment, without a jump.
- R10: `busy` is high exactly when `dac_oe` is high and the registered target differs from `dac_code`.
- R11: During reset, `dac_code` is 0, `dac_oe` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_setpoint | input | DAC_W | Setpoint value from the processor |
| cpu_wr | input | 1 | Write strobe for the processor setpoint |
| par_bus | input | DAC_W | Setpoint from the external parallel board |
| board_det_n | input | 1 | Low when the parallel board is fitted |
| remote_mode | input | 1 | High when the unit is under remote control |
| mon_only | input | 1 | External controller owns the DAC; monitor only |
| dac_sense | input | DAC_W | DAC bits as seen on the bus, for monitoring |
| ramp_en | input | 1 | Enables interpolated ramping |
| tick_div | input | TICK_W | Clocks per ramp tick, minus one |
| step_size | input | STEP_W | Code change per tick (0 acts as 1) |
| dac_code | output | DAC_W | Code for the DAC |
| dac_oe | output | 1 | High when the block drives the DAC bits |
| busy | output | 1 | Output has not yet reached the target |

## Verification
The hardest case to reach from the ports is a target change that arrives partway through a ramp, right on a tick boundary. On such a cycle the step taken toward the old target and the tick restart overlap.

The bench reaches it as follows:
- It starts a slow ramp and tracks its expected value cycle by cycle.
- Once a known number of ticks has elapsed, it writes a new processor setpoint.
- It checks that the value seen at the capture edge still follows the old ramp.
- It then follows the new ramp from that value.

The tick and step sweeps run every combination of a small divider range and several step sizes, including zero, in both directions.

// File: rtl/dac_ramp_pkg.sv
package dac_ramp_pkg;

    // Which source currently owns the DAC code register.
    typedef enum logic [1:0] {
        SRC_CPU = 2'd0,
        SRC_PAR = 2'd1,
        SRC_MON = 2'd2
    } dac_src_e;

endpackage

// File: rtl/dac_src_select.sv
module dac_src_select #(
    parameter int DAC_W = 24,
    parameter int ACT_W = 20
) (
    input  logic [DAC_W-1:0]     cpu_val,
    input  logic [DAC_W-1:0]     par_bus,
    input  logic                 board_det_n,
    input  logic                 remote_mode,
    input  logic                 mon_only,
    input  logic [DAC_W-1:0]     dac_sense,
    output logic [DAC_W-1:0]     tgt,
    output logic [DAC_W-1:0]     sense_m,
    output dac_ramp_pkg::dac_src_e src
);
    import dac_ramp_pkg::*;

    localparam logic [DAC_W-1:0] ACT_MASK = ~({DAC_W{1'b1}} << ACT_W);

    logic par_sel;

    always_comb begin
        par_sel = !board_det_n && remote_mode;
        if (mon_only) begin
            src = SRC_MON;
        end else if (par_sel) begin
            src = SRC_PAR;
        end else begin
            src = SRC_CPU;
        end
        // Target still follows the selected setpoint while monitoring, so
        // leaving monitor mode resumes toward the current request.
        tgt     = (par_sel ? par_bus : cpu_val) & ACT_MASK;
        sense_m = dac_sense & ACT_MASK;
    end

endmodule

// File: rtl/dac_tick_gen.sv
module dac_tick_gen #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [TICK_W-1:0] tick_div,
    output logic              tick
);
    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && !restart && (cnt_q == tick_div);
        cnt_d = cnt_q + TICK_W'(1);
        if (!run || restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dac_ramp_step.sv
module dac_ramp_step #(
    parameter int DAC_W  = 24,
    parameter int STEP_W = 20
) (
    input  logic [DAC_W-1:0]  cur,
    input  logic [DAC_W-1:0]  tgt,
    input  logic [STEP_W-1:0] step_size,
    output logic [DAC_W-1:0]  nxt
);
    logic [DAC_W-1:0] step_e;
    logic [DAC_W-1:0] gap;

    always_comb begin
        step_e = (step_size == '0) ? DAC_W'(1) : DAC_W'(step_size);
        if (tgt >= cur) begin
            gap = tgt - cur;
            nxt = (gap <= step_e) ? tgt : cur + step_e;
        end else begin
            gap = cur - tgt;
            nxt = (gap <= step_e) ? tgt : cur - step_e;
        end
    end

endmodule

// File: rtl/dac_setpoint_ramp.sv
module dac_setpoint_ramp #(
    parameter int DAC_W  = 24,
    parameter int ACT_W  = 20,
    parameter int TICK_W = 16,
    parameter int STEP_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DAC_W-1:0]  cpu_setpoint,
    input  logic              cpu_wr,
    input  logic [DAC_W-1:0]  par_bus,
    input  logic              board_det_n,
    input  logic              remote_mode,
    input  logic              mon_only,
    input  logic [DAC_W-1:0]  dac_sense,
    input  logic              ramp_en,
    input  logic [TICK_W-1:0] tick_div,
    input  logic [STEP_W-1:0] step_size,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_oe,
    output logic              busy
);
    import dac_ramp_pkg::*;

    typedef struct packed {
        logic [DAC_W-1:0] cpu;
        logic [DAC_W-1:0] tgt;
        logic [DAC_W-1:0] out;
        logic             oe;
    } state_t;

    state_t st_d, st_q;

    logic [DAC_W-1:0] tgt_c;
    logic [DAC_W-1:0] sense_m;
    logic [DAC_W-1:0] ramp_nxt;
    logic [DAC_W-1:0] tgt_q_w;
    dac_src_e         src;
    logic             run;
    logic             retarget;
    logic             tick;

    dac_src_select #(.DAC_W(DAC_W), .ACT_W(ACT_W)) sel_i (
        .cpu_val     (st_q.cpu),
        .par_bus     (par_bus),
        .board_det_n (board_det_n),
        .remote_mode (remote_mode),
        .mon_only    (mon_only),
        .dac_sense   (dac_sense),
        .tgt         (tgt_c),
        .sense_m     (sense_m),
        .src         (src)
    );

    dac_tick_gen #(.TICK_W(TICK_W)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (retarget),
        .tick_div (tick_div),
        .tick     (tick)
    );

    dac_ramp_step #(.DAC_W(DAC_W), .STEP_W(STEP_W)) step_i (
        .cur       (st_q.out),
        .tgt       (tgt_c),
        .step_size (step_size),
        .nxt       (ramp_nxt)
    );

    always_comb begin
        run      = ramp_en && (src != SRC_MON);
        retarget = (tgt_c != st_q.tgt);

        st_d     = st_q;
        if (cpu_wr) begin
            st_d.cpu = cpu_setpoint;
        end
        st_d.tgt = tgt_c;
        st_d.oe  = (src != SRC_MON);

        if (src == SRC_MON) begin
            st_d.out = sense_m;
        end else if (!ramp_en) begin
            st_d.out = tgt_c;
        end else if (tick) begin
            st_d.out = ramp_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_q_w  = st_q.tgt;
    assign dac_code = st_q.out;
    assign dac_oe   = st_q.oe;
    assign busy     = st_q.oe && (st_q.out != tgt_q_w);

endmodule

// File: rtl/dac_ramp_chk.sv
module dac_ramp_chk #(
    parameter int DAC_W  = 24,
    parameter int ACT_W  = 20,
    parameter int STEP_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ramp_en,
    input logic              mon_only,
    input logic [DAC_W-1:0]  dac_sense,
    input logic [STEP_W-1:0] step_size,
    input logic [DAC_W-1:0]  dac_code,
    input logic              dac_oe,
    input logic              busy,
    input logic [DAC_W-1:0]  tgt_c,
    input logic [DAC_W-1:0]  tgt_q
);
    localparam logic [DAC_W-1:0] ACT_MASK = ~({DAC_W{1'b1}} << ACT_W);

    logic [DAC_W-1:0] step_e;
    assign step_e = (step_size == '0) ? DAC_W'(1) : DAC_W'(step_size);

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code & ~ACT_MASK) == '0); // R1

    AST_MON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_only |=> (!dac_oe && dac_code == ($past(dac_sense) & ACT_MASK))); // R5

    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_en && !mon_only) |=> dac_code == $past(tgt_c)); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && !mon_only && tgt_c == tgt_q) |=>
        (((dac_code >= $past(dac_code)) ? (dac_code - $past(dac_code))
                                         : ($past(dac_code) - dac_code)) <= $past(step_e))); // R7

    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_only && tgt_c == tgt_q && dac_code <= tgt_q) |=> dac_code <= $past(tgt_q)); // R8

    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_only && tgt_c == tgt_q && dac_code >= tgt_q) |=> dac_code >= $past(tgt_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_only && dac_oe && !busy && tgt_c == tgt_q) |=> $stable(dac_code)); // R10

endmodule

bind dac_setpoint_ramp dac_ramp_chk #(
    .DAC_W  (DAC_W),
    .ACT_W  (ACT_W),
    .STEP_W (STEP_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_en   (ramp_en),
    .mon_only  (mon_only),
    .dac_sense (dac_sense),
    .step_size (step_size),
    .dac_code  (dac_code),
    .dac_oe    (dac_oe),
    .busy      (busy),
    .tgt_c     (tgt_c),
    .tgt_q     (tgt_q_w)
);

// File: tb/dac_setpoint_ramp_tb.sv
module dac_setpoint_ramp_tb_top;

    localparam int DAC_W  = 8;
    localparam int ACT_W  = 6;
    localparam int TICK_W = 3;
    localparam int STEP_W = 4;
    localparam int MASK   = (1 << ACT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DAC_W-1:0]  cpu_setpoint = '0;
    logic              cpu_wr = 1'b0;
    logic [DAC_W-1:0]  par_bus = '0;
    logic              board_det_n = 1'b1;
    logic              remote_mode = 1'b0;
    logic              mon_only = 1'b0;
    logic [DAC_W-1:0]  dac_sense = '0;
    logic              ramp_en = 1'b0;
    logic [TICK_W-1:0] tick_div = '0;
    logic [STEP_W-1:0] step_size = '0;
    logic [DAC_W-1:0]  dac_code;
    logic              dac_oe;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dac_setpoint_ramp #(
        .DAC_W(DAC_W), .ACT_W(ACT_W), .TICK_W(TICK_W), .STEP_W(STEP_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_setpoint(cpu_setpoint), .cpu_wr(cpu_wr),
        .par_bus(par_bus), .board_det_n(board_det_n), .remote_mode(remote_mode),
        .mon_only(mon_only), .dac_sense(dac_sense), .ramp_en(ramp_en),
        .tick_div(tick_div), .step_size(step_size), .dac_code(dac_code),
        .dac_oe(dac_oe), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model(input int s, input int t, input int k, input int se);
        if (t >= s) return (s + k * se > t) ? t : s + k * se;
        return (s - k * se < t) ? t : s - k * se;
    endfunction

    task automatic write_cpu(input int v);
        cpu_setpoint = v[DAC_W-1:0];
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Write a processor target and track the ramp for maxj samples (R7, R8, R10).
    task automatic ramp_track(input int t, input int d, input int s, input int maxj,
                              output int start);
        int se;
        se = (s == 0) ? 1 : s;
        write_cpu(t);
        start = int'(dac_code);
        @(negedge clk);
        for (int j = 0; j < maxj; j++) begin
            int e;
            e = model(start, t & MASK, j / (d + 1), se);
            check(int'(dac_code) == e, "R7", int'(dac_code), e);
            check(busy == (e != (t & MASK)), "R10", int'(busy), int'(e != (t & MASK)));
            @(negedge clk);
        end
    endtask

    initial begin
        int st;
        int se;
        int nst;
        // R11: reset state
        repeat (3) @(negedge clk);
        check(dac_code == '0, "R11", int'(dac_code), 0);
        check(dac_oe == 1'b0, "R11", int'(dac_oe), 0);
        check(busy == 1'b0, "R11", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_oe == 1'b1, "R11", int'(dac_oe), 1);

        // R2, R1: processor path sweep in direct mode
        for (int v = 0; v < 256; v++) begin
            write_cpu(v);
            @(negedge clk);
            check(int'(dac_code) == (v & MASK), "R2", int'(dac_code), v & MASK);
        end

        // R4: parallel bus ignored unless board present and remote
        write_cpu(8'h15);
        for (int c = 0; c < 4; c++) begin
            board_det_n = c[0];
            remote_mode = c[1];
            par_bus = 8'hEA;
            @(negedge clk);
            if (c == 2) check(int'(dac_code) == (8'hEA & MASK), "R3", int'(dac_code), 8'hEA & MASK);
            else check(int'(dac_code) == 8'h15, "R4", int'(dac_code), 8'h15);
        end

        // R3, R1: parallel path sweep
        board_det_n = 1'b0;
        remote_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            par_bus = v[DAC_W-1:0];
            @(negedge clk);
            check(int'(dac_code) == (v & MASK), "R3", int'(dac_code), v & MASK);
            check(dac_code[DAC_W-1:ACT_W] == '0, "R1", int'(dac_code), v & MASK);
        end
        board_det_n = 1'b1;
        remote_mode = 1'b0;
        write_cpu(0);
        @(negedge clk);
        check(dac_code == '0, "R2", int'(dac_code), 0);

        // R5: monitor mode
        mon_only = 1'b1;
        ramp_en = 1'b1;
        for (int v = 0; v < 256; v += 17) begin
            dac_sense = v[DAC_W-1:0];
            cpu_setpoint = 8'h2C;
            cpu_wr = 1'b1;
            @(negedge clk);
            check(dac_oe == 1'b0, "R5", int'(dac_oe), 0);
            check(int'(dac_code) == (v & MASK), "R5", int'(dac_code), v & MASK);
            check(busy == 1'b0, "R10", int'(busy), 0);
        end
        cpu_wr = 1'b0;
        ramp_en = 1'b0;
        mon_only = 1'b0;
        @(negedge clk);
        check(dac_oe == 1'b1, "R5", int'(dac_oe), 1);
        check(int'(dac_code) == 8'h2C, "R6", int'(dac_code), 8'h2C);
        write_cpu(0);
        @(negedge clk);

        // R7, R8: ramp sweep over dividers and steps, up then down
        ramp_en = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int si = 0; si < 4; si++) begin
                int s;
                s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 3 : 7;
                se = (s == 0) ? 1 : s;
                tick_div = d[TICK_W-1:0];
                step_size = s[STEP_W-1:0];
                @(negedge clk);
                st = int'(dac_code);
                ramp_track(8'h3A, d, s, ((8'h3A - st + se - 1) / se) * (d + 1) + 3, nst);
                check(int'(dac_code) == 8'h3A, "R8", int'(dac_code), 8'h3A);
                ramp_track(8'h05, d, s, ((8'h3A - 8'h05 + se - 1) / se) * (d + 1) + 3, nst);
                check(int'(dac_code) == 8'h05, "R8", int'(dac_code), 8'h05);
            end
        end

        // R9: retarget mid-ramp, d=1, s=2, from 5 toward 0x30
        tick_div = 3'd1;
        step_size = 4'd2;
        @(negedge clk);
        ramp_track(8'h30, 1, 2, 9, st);
        // now at sample j=9; the write lands at edge j=10 following the old ramp
        write_cpu(8'h10);
        check(int'(dac_code) == model(st, 8'h30, 10 / 2, 2), "R9", int'(dac_code),
              model(st, 8'h30, 10 / 2, 2));
        nst = int'(dac_code);
        @(negedge clk);
        for (int j = 0; j < 24; j++) begin
            int e;
            e = model(nst, 8'h10, j / 2, 2);
            check(int'(dac_code) == e, "R9", int'(dac_code), e);
            @(negedge clk);
        end
        check(int'(dac_code) == 8'h10, "R8", int'(dac_code), 8'h10);

        // R6: dropping ramp_en mid-ramp jumps to target
        tick_div = 3'd3;
        step_size = 4'd1;
        write_cpu(8'h3F);
        repeat (6) @(negedge clk);
        check(busy == 1'b1, "R10", int'(busy), 1);
        ramp_en = 1'b0;
        @(negedge clk);
        check(int'(dac_code) == 8'h3F, "R6", int'(dac_code), 8'h3F);
        check(busy == 1'b0, "R10", int'(busy), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule